// File: doc/BRIEF.md
# Serial Audio Clock Fault Monitor

This block checks the bit clock and frame sync of a multi-slot serial audio port against a faster, free-running reference clock. On every frame it counts the bit-clock rising edges between two frame-sync rising edges, and it counts the reference cycles in the same interval. The first count must be one of a set of power-of-two bit clocks per frame. The second count must fall inside one of a set of period windows, one window for each supported sample rate. The block also watches each line for a stall. A line has stalled when it shows no transition within a programmable number of reference cycles.

The block locks when two consecutive frames are valid and agree on both the ratio and the rate window. Once it is locked, a frame that differs from the locked setting counts as a change during operation, not as an invalid setting. Four fault causes are held separately:

- an invalid ratio or rate before lock,
- a frame rate change after lock,
- a ratio change after lock,
- a stalled line.

Each cause raises a one-cycle event toward the interrupt logic. While any cause is pending, the block holds a level request that forces a fast software shutdown. When a clean lock returns, the block clears all causes and pulses a restore strobe, so that playback can ramp back to where it was.

Top module: `sacfm_clock_monitor`

## Requirements
- R1: While not locked, a frame whose bit-clock count is not 2^(RATIO_LOG2_MIN+k) for some k below NUM_RATIOS sets cause bit 0 (invalid setting).
- R2: While not locked, a frame whose reference-cycle length lies outside every [RATE_MIN[j], RATE_MAX[j]] window sets cause bit 0.
- R3: Cause bit 3 is set and `clk_good_o` drops when the bit clock shows no edge for `bclk_halt_lim_i` reference cycles, or when the frame sync shows no edge for `fsync_halt_lim_i` reference cycles.
- R4: Two consecutive frames that are both valid and agree on ratio and rate window raise `clk_good_o` and clear every cause bit. `ratio_idx_o` then reports k, where 0 is the smallest ratio, and `rate_idx_o` reports the window index j. Causes clear only at lock.
- R5: While locked, a frame whose ratio differs from the locked ratio (or is invalid) sets cause bit 2 and drops `clk_good_o`.
- R6: While locked, a frame whose rate window differs from the locked window (or matches none) sets cause bit 1 and drops `clk_good_o`.
- R7: `clk_err_o` is high exactly while any cause bit is set. It is never high together with `clk_good_o`.
- R8: `event_o[i]` is a one-cycle pulse in the cycle in which `cause_o[i]` goes from 0 to 1.
- R9: `restore_o` pulses for one cycle when lock is reached while causes were pending. It does not pulse on a frame that keeps an existing lock.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous |
| fsync_i | input | 1 | Frame sync, asynchronous |
| bclk_halt_lim_i | input | HALT_W | Idle reference cycles before the bit clock counts as stalled |
| fsync_halt_lim_i | input | HALT_W | Idle reference cycles before the frame sync counts as stalled |
| clk_err_o | output | 1 | Shutdown request, high while any cause is pending |
| clk_good_o | output | 1 | Locked to a valid ratio and rate |
| restore_o | output | 1 | One-cycle strobe when lock returns after a fault |
| cause_o | output | 4 | Pending causes: 0 invalid, 1 rate change, 2 ratio change, 3 stall |
| event_o | output | 4 | One-cycle pulse when the matching cause bit is set |
| ratio_idx_o | output | RIDX_W | Locked ratio index |
| rate_idx_o | output | PIDX_W | Locked rate window index |

## Verification
Frame results appear on the fourth reference edge after the frame-sync transition that closes the frame: two synchronizer stages, the edge register, the meter register, then the lock controller. A stall appears a few cycles after the idle count reaches its limit. The bench keeps the serial clocks running without gaps across the segments of a run, so that no frame is stretched. It reads results at the end of a segment, at least one whole frame after the edge that produced them. It reads stall results only after waiting twice the limit. Event and restore pulses are counted by a monitor on the falling edge, and the bench reads the counts 1 ns after a falling edge so that the two never race.

// File: rtl/sacfm_pkg.sv
package sacfm_pkg;
  localparam int unsigned CAUSE_W     = 4;
  localparam int unsigned C_INVALID   = 0;
  localparam int unsigned C_RATE_CHG  = 1;
  localparam int unsigned C_RATIO_CHG = 2;
  localparam int unsigned C_HALT      = 3;
  typedef logic [CAUSE_W-1:0] cause_t;
endpackage

// File: rtl/sacfm_edge_det.sv
module sacfm_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o,
  output logic edge_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], sig_i};
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign edge_o = sh_q[SYNC_STAGES-1] ^ sh_q[SYNC_STAGES];
endmodule

// File: rtl/sacfm_frame_meter.sv
module sacfm_frame_meter #(
  parameter int unsigned BIT_W  = 11,
  parameter int unsigned PER_W  = 14,
  parameter int unsigned HALT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_rise_i,
  input  logic              bclk_edge_i,
  input  logic              fs_rise_i,
  input  logic              fs_edge_i,
  input  logic [HALT_W-1:0] bclk_lim_i,
  input  logic [HALT_W-1:0] fs_lim_i,
  output logic              frame_vld_o,
  output logic [BIT_W-1:0]  frame_bits_o,
  output logic [PER_W-1:0]  frame_per_o,
  output logic              halt_o
);
  logic [HALT_W-1:0] b_idle_q, f_idle_q;
  logic [BIT_W-1:0]  bit_cnt_q, bits_q;
  logic [PER_W-1:0]  per_cnt_q, per_q;
  logic              armed_q, vld_q, halt_q;

  // idle counters saturate; stall is a registered compare
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_idle_q <= '0;
      f_idle_q <= '0;
      halt_q   <= 1'b0;
    end else begin
      if (bclk_edge_i)          b_idle_q <= '0;
      else if (b_idle_q != '1)  b_idle_q <= b_idle_q + 1'b1;
      if (fs_edge_i)            f_idle_q <= '0;
      else if (f_idle_q != '1)  f_idle_q <= f_idle_q + 1'b1;
      halt_q <= (b_idle_q >= bclk_lim_i) || (f_idle_q >= fs_lim_i);
    end
  end

  // first frame-sync rise after a stall only arms the meter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      vld_q     <= 1'b0;
      bit_cnt_q <= '0;
      per_cnt_q <= '0;
      bits_q    <= '0;
      per_q     <= '0;
    end else begin
      if (halt_q)         armed_q <= 1'b0;
      else if (fs_rise_i) armed_q <= 1'b1;
      vld_q <= fs_rise_i & armed_q & ~halt_q;
      if (fs_rise_i) begin
        bits_q    <= bit_cnt_q;
        per_q     <= per_cnt_q;
        bit_cnt_q <= {{(BIT_W-1){1'b0}}, bclk_rise_i};
        per_cnt_q <= {{(PER_W-1){1'b0}}, 1'b1};
      end else begin
        if (bclk_rise_i && bit_cnt_q != '1) bit_cnt_q <= bit_cnt_q + 1'b1;
        if (per_cnt_q != '1)                per_cnt_q <= per_cnt_q + 1'b1;
      end
    end
  end

  assign frame_vld_o  = vld_q;
  assign frame_bits_o = bits_q;
  assign frame_per_o  = per_q;
  assign halt_o       = halt_q;
endmodule

// File: rtl/sacfm_frame_decode.sv
module sacfm_frame_decode #(
  parameter int unsigned RATIO_LOG2_MIN = 5,
  parameter int unsigned NUM_RATIOS     = 5,
  parameter int unsigned NUM_RATES      = 3,
  parameter int unsigned BIT_W          = 11,
  parameter int unsigned PER_W          = 14,
  parameter int unsigned RIDX_W         = 3,
  parameter int unsigned PIDX_W         = 2,
  parameter logic [NUM_RATES-1:0][PER_W-1:0] RATE_MIN = '0,
  parameter logic [NUM_RATES-1:0][PER_W-1:0] RATE_MAX = '0
) (
  input  logic [BIT_W-1:0]  frame_bits_i,
  input  logic [PER_W-1:0]  frame_per_i,
  output logic              ratio_ok_o,
  output logic [RIDX_W-1:0] ratio_idx_o,
  output logic              rate_ok_o,
  output logic [PIDX_W-1:0] rate_idx_o
);
  logic [NUM_RATIOS-1:0] r_hit;
  logic [NUM_RATES-1:0]  p_hit;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_ratio
    localparam logic [BIT_W-1:0] RVAL = {{(BIT_W-1){1'b0}}, 1'b1} << (RATIO_LOG2_MIN + i);
    assign r_hit[i] = (frame_bits_i == RVAL);
  end

  for (genvar j = 0; j < NUM_RATES; j++) begin : g_rate
    assign p_hit[j] = (frame_per_i >= RATE_MIN[j]) && (frame_per_i <= RATE_MAX[j]);
  end

  // lowest index wins if windows overlap
  always_comb begin
    ratio_idx_o = '0;
    for (int k = NUM_RATIOS - 1; k >= 0; k--)
      if (r_hit[k]) ratio_idx_o = RIDX_W'(k);
    rate_idx_o = '0;
    for (int k = NUM_RATES - 1; k >= 0; k--)
      if (p_hit[k]) rate_idx_o = PIDX_W'(k);
  end

  assign ratio_ok_o = |r_hit;
  assign rate_ok_o  = |p_hit;
endmodule

// File: rtl/sacfm_lock_ctrl.sv
module sacfm_lock_ctrl
  import sacfm_pkg::*;
#(
  parameter int unsigned RIDX_W = 3,
  parameter int unsigned PIDX_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_vld_i,
  input  logic              ratio_ok_i,
  input  logic [RIDX_W-1:0] ratio_idx_i,
  input  logic              rate_ok_i,
  input  logic [PIDX_W-1:0] rate_idx_i,
  input  logic              halt_i,
  output logic              locked_o,
  output cause_t            cause_o,
  output cause_t            event_o,
  output logic              restore_o,
  output logic [RIDX_W-1:0] lock_ratio_o,
  output logic [PIDX_W-1:0] lock_rate_o
);
  logic              locked_q, locked_n;
  cause_t            cause_q, cause_n, event_q;
  logic              restore_q, restore_n;
  logic              cand_vld_q, cand_vld_n;
  logic [RIDX_W-1:0] cand_r_q, cand_r_n, lock_r_q, lock_r_n;
  logic [PIDX_W-1:0] cand_p_q, cand_p_n, lock_p_q, lock_p_n;
  logic              good, r_chg, p_chg;

  always_comb begin
    locked_n   = locked_q;
    cause_n    = cause_q;
    restore_n  = 1'b0;
    cand_vld_n = cand_vld_q;
    cand_r_n   = cand_r_q;
    cand_p_n   = cand_p_q;
    lock_r_n   = lock_r_q;
    lock_p_n   = lock_p_q;
    good       = ratio_ok_i & rate_ok_i;
    r_chg      = !ratio_ok_i || (ratio_idx_i != lock_r_q);
    p_chg      = !rate_ok_i  || (rate_idx_i  != lock_p_q);
    if (halt_i) begin
      locked_n        = 1'b0;
      cand_vld_n      = 1'b0;
      cause_n[C_HALT] = 1'b1;
    end else if (frame_vld_i) begin
      if (locked_q) begin
        if (r_chg || p_chg) begin
          locked_n = 1'b0;
          if (r_chg) cause_n[C_RATIO_CHG] = 1'b1;
          if (p_chg) cause_n[C_RATE_CHG]  = 1'b1;
          cand_vld_n = good;
          cand_r_n   = ratio_idx_i;
          cand_p_n   = rate_idx_i;
        end
      end else if (good) begin
        if (cand_vld_q && cand_r_q == ratio_idx_i && cand_p_q == rate_idx_i) begin
          locked_n  = 1'b1;
          lock_r_n  = ratio_idx_i;
          lock_p_n  = rate_idx_i;
          restore_n = |cause_q;
          cause_n   = '0;
        end else begin
          cand_vld_n = 1'b1;
          cand_r_n   = ratio_idx_i;
          cand_p_n   = rate_idx_i;
        end
      end else begin
        cause_n[C_INVALID] = 1'b1;
        cand_vld_n         = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q   <= 1'b0;
      cause_q    <= '0;
      event_q    <= '0;
      restore_q  <= 1'b0;
      cand_vld_q <= 1'b0;
      cand_r_q   <= '0;
      cand_p_q   <= '0;
      lock_r_q   <= '0;
      lock_p_q   <= '0;
    end else begin
      locked_q   <= locked_n;
      cause_q    <= cause_n;
      event_q    <= cause_n & ~cause_q;
      restore_q  <= restore_n;
      cand_vld_q <= cand_vld_n;
      cand_r_q   <= cand_r_n;
      cand_p_q   <= cand_p_n;
      lock_r_q   <= lock_r_n;
      lock_p_q   <= lock_p_n;
    end
  end

  assign locked_o     = locked_q;
  assign cause_o      = cause_q;
  assign event_o      = event_q;
  assign restore_o    = restore_q;
  assign lock_ratio_o = lock_r_q;
  assign lock_rate_o  = lock_p_q;
endmodule

// File: rtl/sacfm_clock_monitor.sv
module sacfm_clock_monitor
  import sacfm_pkg::*;
#(
  parameter int unsigned RATIO_LOG2_MIN = 5,
  parameter int unsigned NUM_RATIOS     = 5,
  parameter int unsigned NUM_RATES      = 3,
  parameter int unsigned PER_W          = 14,
  parameter int unsigned HALT_W         = 16,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter logic [NUM_RATES-1:0][PER_W-1:0] RATE_MIN = {14'd5556, 14'd5104, 14'd2552},
  parameter logic [NUM_RATES-1:0][PER_W-1:0] RATE_MAX = {14'd5782, 14'd5312, 14'd2656},
  localparam int unsigned BIT_W  = RATIO_LOG2_MIN + NUM_RATIOS + 1,
  localparam int unsigned RIDX_W = (NUM_RATIOS > 1) ? $clog2(NUM_RATIOS) : 1,
  localparam int unsigned PIDX_W = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic [HALT_W-1:0] bclk_halt_lim_i,
  input  logic [HALT_W-1:0] fsync_halt_lim_i,
  output logic              clk_err_o,
  output logic              clk_good_o,
  output logic              restore_o,
  output logic [3:0]        cause_o,
  output logic [3:0]        event_o,
  output logic [RIDX_W-1:0] ratio_idx_o,
  output logic [PIDX_W-1:0] rate_idx_o
);
  logic              b_rise, b_edge, f_rise, f_edge;
  logic              frame_vld, halt_w;
  logic [BIT_W-1:0]  frame_bits;
  logic [PER_W-1:0]  frame_per;
  logic              ratio_ok, rate_ok;
  logic [RIDX_W-1:0] ratio_idx;
  logic [PIDX_W-1:0] rate_idx;
  cause_t            cause_w, event_w;

  sacfm_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_bclk_det (
    .clk_i, .rst_ni, .sig_i(bclk_i), .rise_o(b_rise), .edge_o(b_edge)
  );

  sacfm_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_fs_det (
    .clk_i, .rst_ni, .sig_i(fsync_i), .rise_o(f_rise), .edge_o(f_edge)
  );

  sacfm_frame_meter #(.BIT_W(BIT_W), .PER_W(PER_W), .HALT_W(HALT_W)) u_meter (
    .clk_i, .rst_ni,
    .bclk_rise_i(b_rise), .bclk_edge_i(b_edge),
    .fs_rise_i(f_rise), .fs_edge_i(f_edge),
    .bclk_lim_i(bclk_halt_lim_i), .fs_lim_i(fsync_halt_lim_i),
    .frame_vld_o(frame_vld), .frame_bits_o(frame_bits),
    .frame_per_o(frame_per), .halt_o(halt_w)
  );

  sacfm_frame_decode #(
    .RATIO_LOG2_MIN(RATIO_LOG2_MIN), .NUM_RATIOS(NUM_RATIOS), .NUM_RATES(NUM_RATES),
    .BIT_W(BIT_W), .PER_W(PER_W), .RIDX_W(RIDX_W), .PIDX_W(PIDX_W),
    .RATE_MIN(RATE_MIN), .RATE_MAX(RATE_MAX)
  ) u_decode (
    .frame_bits_i(frame_bits), .frame_per_i(frame_per),
    .ratio_ok_o(ratio_ok), .ratio_idx_o(ratio_idx),
    .rate_ok_o(rate_ok), .rate_idx_o(rate_idx)
  );

  sacfm_lock_ctrl #(.RIDX_W(RIDX_W), .PIDX_W(PIDX_W)) u_lock (
    .clk_i, .rst_ni,
    .frame_vld_i(frame_vld), .ratio_ok_i(ratio_ok), .ratio_idx_i(ratio_idx),
    .rate_ok_i(rate_ok), .rate_idx_i(rate_idx), .halt_i(halt_w),
    .locked_o(clk_good_o), .cause_o(cause_w), .event_o(event_w),
    .restore_o(restore_o), .lock_ratio_o(ratio_idx_o), .lock_rate_o(rate_idx_o)
  );

  assign cause_o   = cause_w;
  assign event_o   = event_w;
  assign clk_err_o = |cause_w;
endmodule

// File: rtl/sacfm_clock_monitor_chk.sv
module sacfm_clock_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       halt_i,
  input logic       clk_err_o,
  input logic       clk_good_o,
  input logic       restore_o,
  input logic [3:0] cause_o,
  input logic [3:0] event_o
);
  assert_halt_sets_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> (cause_o[3] && !clk_good_o));

  assert_lock_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_good_o) |-> (cause_o == 4'b0000));

  assert_cause_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_good_o |-> ((cause_o & $past(cause_o)) == $past(cause_o)));

  assert_good_err_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_good_o |-> !clk_err_o);

  assert_event_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_o) |=> ((event_o & $past(event_o)) == 4'b0000));

  assert_event_has_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_o) |-> ((event_o & ~cause_o) == 4'b0000));

  assert_restore_after_fault_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |-> (clk_good_o && $past(clk_err_o)));
endmodule

bind sacfm_clock_monitor sacfm_clock_monitor_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .halt_i(halt_w),
  .clk_err_o(clk_err_o), .clk_good_o(clk_good_o), .restore_o(restore_o),
  .cause_o(cause_o), .event_o(event_o)
);

// File: tb/sacfm_clock_monitor_tb_top.sv
`timescale 1ns/100ps
module sacfm_clock_monitor_tb_top;
  localparam int unsigned L2MIN = 2;
  localparam int unsigned NRAT  = 3;
  localparam int unsigned NRATE = 2;
  localparam int unsigned PW    = 14;
  localparam int unsigned HW    = 16;
  localparam int          BLIM  = 40;
  localparam int          FLIM  = 300;
  localparam int          WMIN0 = 60, WMAX0 = 68, WMIN1 = 124, WMAX1 = 132;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0;
  logic clk_err, clk_good, restore;
  logic [3:0] cause, event_v;
  logic [1:0] ratio_idx;
  logic       rate_idx;

  int checks = 0, fails = 0;
  int ev_cnt [4];
  int rs_cnt = 0;
  int base_ev [4];
  int base_rs;

  always #2 clk = ~clk;

  sacfm_clock_monitor #(
    .RATIO_LOG2_MIN(L2MIN), .NUM_RATIOS(NRAT), .NUM_RATES(NRATE),
    .PER_W(PW), .HALT_W(HW),
    .RATE_MIN({14'd124, 14'd60}), .RATE_MAX({14'd132, 14'd68})
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .fsync_i(fsync),
    .bclk_halt_lim_i(HW'(BLIM)), .fsync_halt_lim_i(HW'(FLIM)),
    .clk_err_o(clk_err), .clk_good_o(clk_good), .restore_o(restore),
    .cause_o(cause), .event_o(event_v), .ratio_idx_o(ratio_idx), .rate_idx_o(rate_idx)
  );

  initial for (int i = 0; i < 4; i++) ev_cnt[i] = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 4; i++) if (event_v[i]) ev_cnt[i] = ev_cnt[i] + 1;
      if (restore) rs_cnt = rs_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic snap();
    for (int i = 0; i < 4; i++) base_ev[i] = ev_cnt[i];
    base_rs = rs_cnt;
  endtask

  function automatic int exp_ratio_idx(input int ratio);
    return $clog2(ratio) - L2MIN;
  endfunction

  function automatic int exp_rate_idx(input int per);
    if (per >= WMIN0 && per <= WMAX0) return 0;
    if (per >= WMIN1 && per <= WMAX1) return 1;
    return -1;
  endfunction

  // bit count 'ratio', bit period 2*half reference cycles
  task automatic drive_frames(input int ratio, input int half, input int nfr, input bit fs_en);
    for (int f = 0; f < nfr; f++) begin
      for (int b = 0; b < ratio; b++) begin
        @(negedge clk);
        bclk  = 1'b0;
        fsync = fs_en && (b == 0);
        repeat (half - 1) @(negedge clk);
        @(negedge clk);
        bclk = 1'b1;
        repeat (half - 1) @(negedge clk);
      end
    end
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  int cr [6] = '{4, 8, 16, 8, 16, 4};
  int ch [6] = '{8, 4, 2, 8, 4, 16};

  initial begin
    int unsigned seed_v;
    int prev, cur, nfr;
    int e_rchg, e_pchg, e_rs;
    seed_v = $urandom(32'h5ac0_0017);

    // reset state
    repeat (5) @(negedge clk);
    settle();
    chk_eq("R10 err in reset", int'(clk_err), 0);
    chk_eq("R10 cause in reset", int'(cause), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    settle();
    chk_eq("R10 good after reset", int'(clk_good), 0);
    chk_eq("R10 event after reset", int'(event_v), 0);
    chk_eq("R10 restore after reset", int'(restore), 0);

    // idle lines after reset -> stall cause
    repeat (60) @(negedge clk);
    settle();
    chk_eq("R3 stall cause at start", int'(cause), 4'b1000);
    chk_eq("R7 err with cause", int'(clk_err), 1);
    chk_eq("R8 stall event count", ev_cnt[3], 1);

    // lock on 8 bits / 64 cycles
    drive_frames(8, 4, 5, 1'b1);
    settle();
    chk_eq("R4 locked", int'(clk_good), 1);
    chk_eq("R4 causes cleared", int'(cause), 0);
    chk_eq("R7 err low when locked", int'(clk_err), 0);
    chk_eq("R4 ratio idx", int'(ratio_idx), exp_ratio_idx(8));
    chk_eq("R4 rate idx", int'(rate_idx), exp_rate_idx(64));
    chk_eq("R9 restore count", rs_cnt, 1);

    // ratio change, same rate
    snap();
    drive_frames(16, 2, 2, 1'b1);
    settle();
    chk_eq("R5 ratio change cause", int'(cause), 4'b0100);
    chk_eq("R5 good dropped", int'(clk_good), 0);
    chk_eq("R8 ratio event", ev_cnt[2] - base_ev[2], 1);
    chk_eq("R8 no rate event", ev_cnt[1] - base_ev[1], 0);
    drive_frames(16, 2, 2, 1'b1);
    settle();
    chk_eq("R4 relock ratio idx", int'(ratio_idx), exp_ratio_idx(16));
    chk_eq("R9 restore after ratio change", rs_cnt - base_rs, 1);

    // rate change, same ratio
    snap();
    drive_frames(16, 4, 2, 1'b1);
    settle();
    chk_eq("R6 rate change cause", int'(cause), 4'b0010);
    chk_eq("R6 good dropped", int'(clk_good), 0);
    chk_eq("R8 rate event", ev_cnt[1] - base_ev[1], 1);
    drive_frames(16, 4, 2, 1'b1);
    settle();
    chk_eq("R4 relock rate idx", int'(rate_idx), exp_rate_idx(128));
    chk_eq("R4 relocked", int'(clk_good), 1);

    // bit clock stall while locked
    snap();
    repeat (2 * BLIM) @(negedge clk);
    settle();
    chk_eq("R3 bclk stall cause", int'(cause), 4'b1000);
    chk_eq("R3 good dropped on stall", int'(clk_good), 0);

    // invalid ratio (6 bits, 60 cycles)
    drive_frames(6, 5, 4, 1'b1);
    settle();
    chk_eq("R1 invalid ratio cause", int'(cause), 4'b1001);
    chk_eq("R8 invalid event", ev_cnt[0] - base_ev[0], 1);
    chk_eq("R1 not locked", int'(clk_good), 0);
    drive_frames(8, 4, 5, 1'b1);
    settle();
    chk_eq("R4 relock after invalid", int'(clk_good), 1);

    // invalid rate (8 bits, 96 cycles)
    snap();
    repeat (2 * BLIM) @(negedge clk);
    drive_frames(8, 6, 4, 1'b1);
    settle();
    chk_eq("R2 invalid rate cause", int'(cause), 4'b1001);
    chk_eq("R2 invalid event", ev_cnt[0] - base_ev[0], 1);
    drive_frames(8, 4, 5, 1'b1);
    settle();
    chk_eq("R9 restore after invalid rate", rs_cnt - base_rs, 1);

    // frame sync stuck low with bit clock running
    snap();
    drive_frames(8, 4, 6, 1'b0);
    settle();
    chk_eq("R3 fsync stall cause", int'(cause), 4'b1000);
    chk_eq("R3 fsync stall event", ev_cnt[3] - base_ev[3], 1);
    drive_frames(8, 4, 5, 1'b1);
    settle();
    chk_eq("R4 relock after fsync stall", int'(clk_good), 1);

    // random segments of valid settings, no gaps between them
    prev = 1;
    e_rchg = ev_cnt[2]; e_pchg = ev_cnt[1]; e_rs = rs_cnt;
    for (int s = 0; s < 12; s++) begin
      cur = int'($urandom % 6);
      nfr = 3 + int'($urandom % 3);
      if (exp_ratio_idx(cr[cur]) != exp_ratio_idx(cr[prev])) e_rchg++;
      if (exp_rate_idx(2 * cr[cur] * ch[cur]) != exp_rate_idx(2 * cr[prev] * ch[prev])) e_pchg++;
      if (exp_ratio_idx(cr[cur]) != exp_ratio_idx(cr[prev]) ||
          exp_rate_idx(2 * cr[cur] * ch[cur]) != exp_rate_idx(2 * cr[prev] * ch[prev])) e_rs++;
      drive_frames(cr[cur], ch[cur], nfr, 1'b1);
      settle();
      chk_eq("R4 random locked", int'(clk_good), 1);
      chk_eq("R4 random ratio idx", int'(ratio_idx), exp_ratio_idx(cr[cur]));
      chk_eq("R4 random rate idx", int'(rate_idx), exp_rate_idx(2 * cr[cur] * ch[cur]));
      chk_eq("R5 random ratio events", ev_cnt[2], e_rchg);
      chk_eq("R6 random rate events", ev_cnt[1], e_pchg);
      chk_eq("R9 random restores", rs_cnt, e_rs);
      prev = cur;
    end

    finish_run();
  end
endmodule